// File: doc/BRIEF.md
# Per-Port Egress Timestamp Capture and Interrupt Unit

This block sits beside one switch port and records the departure time of three kinds of timing event frame: the peer-delay response (source 0), the delay or peer-delay request (source 1) and sync (source 2). Each source has its own timestamp holding register. A capture pulse on a source latches the stamp that comes with it and sets that source's pending bit. The pending bits sit in a 16-bit status word starting at bit 13. A 16-bit enable word uses the same bit positions. Any pending bit that is also enabled drives a single interrupt line.

Software reads the status word and writes the same value back to clear it, since the bits are write-one-to-clear. It then fetches the stamps it was told about. A captured stamp carries only the two low seconds bits, above a 30-bit nanoseconds field. A separate rebuild path turns such a partial stamp into full seconds. It takes the seconds from a reference time and moves the result by four seconds when it lands outside a window around that reference.

Top module: `egts_capture_irq`

## Requirements
- R1: After synchronous reset, all stamp registers, the status word, the enable word, `irq_o`, `rd_data_o` and `rc_valid_o` are zero.
- R2: When `cap_valid_i[i]` is high at a clock edge, `cap_stamp_i` is stored in the stamp register of source i and status bit 13+i is set. Stamp registers are read at address 2+i.
- R3: A capture on a source whose status bit is already set replaces the stored stamp, and the bit stays set.
- R4: A write to address 0 clears each status bit 13..15 whose `wr_data_i` bit is 1. Bits written 0 keep their value. A capture in the same cycle takes priority, so its bit stays set.
- R5: The enable word at address 1 stores `wr_data_i` bits 13..15. All other bits of the enable word read as 0.
- R6: `irq_o` is high in the cycle after one in which some status bit and the matching enable bit are both set, and low in the cycle after one in which no such pair exists.
- R7: A read request with `rd_en_i` returns data on `rd_data_o` after the next clock edge. Status and enable words are zero-extended. Addresses 5 to 7 read as 0.
- R8: One cycle after `rc_valid_i`, `rc_valid_o` is high. `rc_ns_o` equals the low 30 bits of `rc_part_i`. The low 2 bits of `rc_sec_o` equal `rc_part_i[31:30]`, before the R9 correction, which leaves these 2 bits unchanged.
- R9: Let d be the whole-second floor of (rebuilt time minus reference time), where the rebuilt time is the reference seconds with the low 2 bits replaced plus the partial nanoseconds. If d > 2, 4 s are subtracted. If d < -2, 4 s are added. Seconds wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid_i | input | 3 | Per-source capture strobe (0 resp, 1 request, 2 sync) |
| cap_stamp_i | input | 32 | Partial stamp: seconds low bits [31:30], nanoseconds [29:0] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0 status, 1 enable) |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |
| rc_valid_i | input | 1 | Rebuild request |
| rc_part_i | input | 32 | Partial stamp to rebuild |
| rc_ref_sec_i | input | 32 | Reference seconds |
| rc_ref_ns_i | input | 30 | Reference nanoseconds |
| rc_valid_o | output | 1 | Rebuild result valid |
| rc_sec_o | output | 32 | Full seconds |
| rc_ns_o | output | 30 | Nanoseconds |

## Verification
Some internal faults show up at the ports within a cycle or two: a pending bit that sticks, a clear aimed at the wrong bit, or a lost enable. They appear in the next status read and in `irq_o` one edge after the status changes. A stamp latched into the wrong source shows up on the next read of that source's address. A wrong borrow or window comparison in the rebuild path gives seconds that are off by exactly four, on the very next edge. The vectors sit right at the ±2 s window edges and on the nanosecond borrow so that such faults cannot hide.

// File: rtl/egts_pkg.sv
package egts_pkg;
  localparam int NSRC    = 3;
  localparam int IRQ_LSB = 13;
  localparam int ADDR_W  = 3;
  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 3'd0,
    ADR_ENABLE = 3'd1,
    ADR_STAMP0 = 3'd2
  } egts_addr_e;
endpackage

// File: rtl/egts_stamp_reg.sv
module egts_stamp_reg #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [STAMP_W-1:0] stamp_i,
  output logic [STAMP_W-1:0] stamp_o
);
  always_ff @(posedge clk) begin
    if (rst)         stamp_o <= '0;
    else if (load_i) stamp_o <= stamp_i;
  end

  // R3: a stamp holds its value unless a capture arrives
  a_r3_hold_stamp: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(stamp_o));
endmodule

// File: rtl/egts_irq_status.sv
module egts_irq_status #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] cap_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_bits_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_bits_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      en_o   <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= cap_i | (pend_o & ~clr_eff);
      if (en_we_i) en_o <= en_bits_i;
      irq_o  <= |(pend_o & en_o);
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R2: a pending bit only rises after a capture
    a_r2_rise_needs_cap: assert property (@(posedge clk) disable iff (rst)
      (!cap_i[i] && !pend_o[i]) |=> !pend_o[i]);
    // R4: a clear without a concurrent capture empties the bit
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
      (clr_we_i && clr_bits_i[i] && !cap_i[i]) |=> !pend_o[i]);
    // R4: capture wins over clear
    a_r4_cap_wins: assert property (@(posedge clk) disable iff (rst)
      cap_i[i] |=> pend_o[i]);
  end

  // R6: interrupt follows the enabled pending set one cycle later
  a_r6_irq_set: assert property (@(posedge clk) disable iff (rst)
    (|(pend_o & en_o)) |=> irq_o);
  a_r6_irq_clr: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_o & en_o)) |=> !irq_o);
endmodule

// File: rtl/egts_rebuild.sv
module egts_rebuild #(
  parameter int SEC_W   = 32,
  parameter int SECLO_W = 2,
  parameter int NS_W    = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic [SECLO_W+NS_W-1:0]  part_i,
  input  logic [SEC_W-1:0]         ref_sec_i,
  input  logic [NS_W-1:0]          ref_ns_i,
  output logic                     valid_o,
  output logic [SEC_W-1:0]         sec_o,
  output logic [NS_W-1:0]          ns_o
);
  localparam int WRAP   = 1 << SECLO_W;
  localparam int HALF   = WRAP / 2;
  localparam int DIFF_W = SECLO_W + 2;
  localparam logic signed [DIFF_W-1:0] WIN_HI = DIFF_W'(HALF);
  localparam logic signed [DIFF_W-1:0] WIN_LO = -DIFF_W'(HALF);

  logic [SECLO_W-1:0]       part_lo;
  logic [NS_W-1:0]          part_ns;
  logic                     borrow;
  logic signed [DIFF_W-1:0] fdiff;
  logic [SEC_W-1:0]         cand, fixed;

  assign part_lo = part_i[SECLO_W+NS_W-1:NS_W];
  assign part_ns = part_i[NS_W-1:0];
  assign borrow  = part_ns < ref_ns_i;
  assign cand    = {ref_sec_i[SEC_W-1:SECLO_W], part_lo};

  always_comb begin
    fdiff = $signed({2'b00, part_lo}) - $signed({2'b00, ref_sec_i[SECLO_W-1:0]})
          - $signed({{(DIFF_W-1){1'b0}}, borrow});
    if (fdiff > WIN_HI)      fixed = cand - SEC_W'(WRAP);
    else if (fdiff < WIN_LO) fixed = cand + SEC_W'(WRAP);
    else                     fixed = cand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sec_o   <= '0;
      ns_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sec_o <= fixed;
        ns_o  <= part_ns;
      end
    end
  end

  // R8: low seconds bits come straight from the partial stamp
  a_r8_low_bits: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (sec_o[SECLO_W-1:0] == $past(part_lo)) && valid_o);
  // R9: the result never moves further than one wrap from the reference
  a_r9_window: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ((sec_o - $past(ref_sec_i)) <= SEC_W'(WRAP)
              || ($past(ref_sec_i) - sec_o) <= SEC_W'(WRAP)));
endmodule

// File: rtl/egts_capture_irq.sv
module egts_capture_irq
  import egts_pkg::*;
#(
  parameter int STAMP_W = 32,
  parameter int SECLO_W = 2,
  parameter int SEC_W   = 32,
  parameter int REG_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         cap_valid_i,
  input  logic [STAMP_W-1:0]      cap_stamp_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [REG_W-1:0]        wr_data_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [STAMP_W-1:0]      rd_data_o,
  output logic                    irq_o,
  input  logic                    rc_valid_i,
  input  logic [STAMP_W-1:0]      rc_part_i,
  input  logic [SEC_W-1:0]        rc_ref_sec_i,
  input  logic [STAMP_W-SECLO_W-1:0] rc_ref_ns_i,
  output logic                    rc_valid_o,
  output logic [SEC_W-1:0]        rc_sec_o,
  output logic [STAMP_W-SECLO_W-1:0] rc_ns_o
);
  localparam int NS_W = STAMP_W - SECLO_W;

  logic [STAMP_W-1:0] stamp_q [NSRC];
  logic [NSRC-1:0]    pend, en;
  logic [REG_W-1:0]   pend_word, en_word;
  logic               clr_we, en_we;

  assign clr_we = wr_en_i && (wr_addr_i == ADR_STATUS);
  assign en_we  = wr_en_i && (wr_addr_i == ADR_ENABLE);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    egts_stamp_reg #(.STAMP_W(STAMP_W)) u_stamp (
      .clk     (clk),
      .rst     (rst),
      .load_i  (cap_valid_i[i]),
      .stamp_i (cap_stamp_i),
      .stamp_o (stamp_q[i])
    );
  end

  egts_irq_status #(.NSRC(NSRC)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (cap_valid_i),
    .clr_we_i   (clr_we),
    .clr_bits_i (wr_data_i[IRQ_LSB +: NSRC]),
    .en_we_i    (en_we),
    .en_bits_i  (wr_data_i[IRQ_LSB +: NSRC]),
    .pend_o     (pend),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  always_comb begin
    pend_word = '0;
    en_word   = '0;
    pend_word[IRQ_LSB +: NSRC] = pend;
    en_word[IRQ_LSB +: NSRC]   = en;
  end

  logic [STAMP_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == ADR_STATUS) rd_mux = STAMP_W'(pend_word);
    if (rd_addr_i == ADR_ENABLE) rd_mux = STAMP_W'(en_word);
    for (int i = 0; i < NSRC; i++)
      if (rd_addr_i == ADDR_W'(int'(ADR_STAMP0) + i)) rd_mux = stamp_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  egts_rebuild #(.SEC_W(SEC_W), .SECLO_W(SECLO_W), .NS_W(NS_W)) u_rebuild (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (rc_valid_i),
    .part_i    (rc_part_i),
    .ref_sec_i (rc_ref_sec_i),
    .ref_ns_i  (rc_ref_ns_i),
    .valid_o   (rc_valid_o),
    .sec_o     (rc_sec_o),
    .ns_o      (rc_ns_o)
  );

  // R7: read data changes only on a read request
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/egts_capture_irq_tb.sv
module egts_capture_irq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cap_valid = '0;
  logic [31:0] cap_stamp = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        rc_valid = 1'b0;
  logic [31:0] rc_part = '0;
  logic [31:0] rc_ref_sec = '0;
  logic [29:0] rc_ref_ns = '0;
  logic        rc_valid_o;
  logic [31:0] rc_sec;
  logic [29:0] rc_ns;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  egts_capture_irq u_dut (
    .clk(clk), .rst(rst), .cap_valid_i(cap_valid), .cap_stamp_i(cap_stamp),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq),
    .rc_valid_i(rc_valid), .rc_part_i(rc_part), .rc_ref_sec_i(rc_ref_sec),
    .rc_ref_ns_i(rc_ref_ns), .rc_valid_o(rc_valid_o), .rc_sec_o(rc_sec),
    .rc_ns_o(rc_ns)
  );

  // {ref_sec, ref_ns, partial stamp, expected seconds}
  localparam logic [127:0] VEC [0:9] = '{
    {32'd100, 32'd500, {2'd0, 30'd600}, 32'd100},
    {32'd100, 32'd500, {2'd3, 30'd600}, 32'd99},
    {32'd100, 32'd500, {2'd3, 30'd400}, 32'd103},
    {32'd101, 32'd0,   {2'd0, 30'd0},   32'd100},
    {32'd103, 32'd500, {2'd0, 30'd600}, 32'd104},
    {32'd102, 32'd500, {2'd0, 30'd600}, 32'd100},
    {32'd102, 32'd500, {2'd0, 30'd400}, 32'd104},
    {32'd2,   32'd10,  {2'd3, 30'd20},  32'd3},
    {32'd1,   32'd100, {2'd3, 30'd200}, 32'd3},
    {32'd0,   32'd0,   {2'd3, 30'd5},   32'hFFFF_FFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_cap(logic [2:0] m, logic [31:0] s);
    @(negedge clk); cap_valid = m; cap_stamp = s;
    @(negedge clk); cap_valid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rc_valid", {31'd0, rc_valid_o}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    do_read(3'd0, d); check("R1 status", d, 32'd0);
    do_read(3'd1, d); check("R1 enable", d, 32'd0);
    for (int i = 0; i < 3; i++) begin
      do_read(3'(2 + i), d); check("R1 stamp", d, 32'd0);
    end

    // R8 R9 rebuild vectors
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      rc_valid = 1'b1;
      rc_ref_sec = VEC[v][127:96];
      rc_ref_ns  = VEC[v][93:64];
      rc_part    = VEC[v][63:32];
      @(negedge clk);
      rc_valid = 1'b0;
      check("R8 valid", {31'd0, rc_valid_o}, 32'd1);
      check("R8 ns", {2'd0, rc_ns}, {2'd0, VEC[v][61:32]});
      check("R9 seconds", rc_sec, VEC[v][31:0]);
    end
    @(negedge clk);
    check("R8 valid drop", {31'd0, rc_valid_o}, 32'd0);

    // R2 capture on request source
    do_cap(3'b010, 32'hA000_1234);
    do_read(3'd3, d); check("R2 stamp src1", d, 32'hA000_1234);
    do_read(3'd2, d); check("R2 src0 untouched", d, 32'd0);
    do_read(3'd0, d); check("R2 status bit14", d, 32'h0000_4000);
    check("R6 irq masked", {31'd0, irq}, 32'd0);

    // R5 enable word, only source bits stored
    do_write(3'd1, 16'hFFFF);
    do_read(3'd1, d); check("R5 enable readback", d, 32'h0000_E000);
    check("R6 irq raised", {31'd0, irq}, 32'd1);

    // R3 recapture overwrites
    do_cap(3'b010, 32'h4BCD_0001);
    do_read(3'd3, d); check("R3 overwrite", d, 32'h4BCD_0001);
    do_read(3'd0, d); check("R3 bit stays", d, 32'h0000_4000);

    // R4 clear with zero and low bits ignored
    do_write(3'd0, 16'h1FFF);
    do_read(3'd0, d); check("R4 zero bits no effect", d, 32'h0000_4000);
    do_write(3'd0, 16'h4000);
    do_read(3'd0, d); check("R4 w1c clear", d, 32'd0);
    check("R6 irq low", {31'd0, irq}, 32'd0);

    // R2 sync and resp sources, partial clear
    do_cap(3'b101, 32'h7777_0000);
    do_read(3'd4, d); check("R2 stamp src2", d, 32'h7777_0000);
    do_read(3'd2, d); check("R2 stamp src0", d, 32'h7777_0000);
    do_write(3'd0, 16'h2000);
    do_read(3'd0, d); check("R4 partial clear", d, 32'h0000_8000);

    // R4 capture wins over same-cycle clear
    @(negedge clk);
    cap_valid = 3'b100; cap_stamp = 32'h0000_0042;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h8000;
    @(negedge clk);
    cap_valid = '0; wr_en = 1'b0;
    do_read(3'd0, d); check("R4 capture priority", d, 32'h0000_8000);

    // R6 enable removed drops irq
    do_write(3'd1, 16'h0000);
    @(negedge clk);
    check("R6 irq disabled", {31'd0, irq}, 32'd0);

    // R7 unmapped address
    do_read(3'd6, d); check("R7 unmapped", d, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule